// File: doc/BRIEF.md
# Dual Compute Unit Barrier Dispatcher

This block hands out tile tasks for one layer to two compute units of unequal size: a large unit whose per-task latency is long, and a small unit whose per-task latency is short. A layer plan gives the number of tasks meant for each unit and the per-task latency of each unit. The latency of each unit scales with its tile width times tile height. The dispatcher works in rounds. A round sends one task to each unit that still has tasks left. The dispatcher then holds back the next round until every unit that received a task has reported completion. The two units run side by side inside a round. The block does not choose the task counts; it only carries out a given plan.

While it runs, the block counts the cycles spent waiting on the units and presents that count as the measured latency. From the same plan it also computes the analytic cost: large latency times large count, plus small latency times the excess of small tasks over large tasks. The excess is taken as zero when it would be negative. The two values can be compared directly. When the small count does not exceed the large count, the small work is hidden under the large rounds and adds nothing.

The control is a four-state machine:
- IDLE: waiting for `start`. `start` moves it to ISSUE, or straight to FIN if both counts are zero.
- ISSUE: lasts one cycle and pulses the issue lines. It always moves to WAIT.
- WAIT: counts cycles. Once every issued unit is done, it moves back to ISSUE if tasks remain, and otherwise to FIN.
- FIN: lasts one cycle and then returns to IDLE.

Top module: `dual_cu_dispatcher`

## Requirements
- R1: After reset, `busy`, `finished`, `issue_big` and `issue_small` are 0, and `total_cycles` and `model_cost` are 0.
- R2: A `start` pulse seen while idle latches the plan, clears `total_cycles`, and raises `busy` in the next cycle.
- R3: Each round pulses `issue_big` for one cycle only while large-unit tasks remain, and `issue_small` only while small-unit tasks remain. Over a run, the issue pulse count on each line equals that unit's task count, and the number of rounds equals the larger of the two counts.
- R4: No new round is issued while any unit given a task in the current round has not yet asserted its done line. A unit's done is its done input being high at a clock edge.
- R5: `total_cycles` counts the cycles spent in WAIT. With units that answer exactly their latency cycles after an issue pulse, it ends equal to `lat_big*num_big + lat_small*max(0, num_small-num_big)`. It holds its value from the end of a run until the next accepted `start`.
- R6: `model_cost` shows `lat_big*num_big + lat_small*max(0, num_small-num_big)` from the cycle after an accepted `start`. When `num_small <= num_big`, this reduces to `lat_big*num_big`.
- R7: A done input from a unit that has no task outstanding in the current round is ignored. It neither ends the round early nor changes the measured count.
- R8: When both counts are exhausted, `finished` is high for exactly one cycle and `busy` falls in the next cycle. A plan with both counts zero finishes with `total_cycles` equal to 0.
- R9: A `start` pulse while `busy` is high is ignored. The running plan, `model_cost` and the measured count are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a layer plan (accepted only when idle) |
| num_big | input | CNT_W | Task count for the large unit |
| num_small | input | CNT_W | Task count for the small unit |
| lat_big | input | LAT_W | Per-task latency of the large unit |
| lat_small | input | LAT_W | Per-task latency of the small unit |
| done_big | input | 1 | Large unit reports task completion |
| done_small | input | 1 | Small unit reports task completion |
| issue_big | output | 1 | One-cycle task pulse to the large unit |
| issue_small | output | 1 | One-cycle task pulse to the small unit |
| busy | output | 1 | A plan is in progress |
| finished | output | 1 | One-cycle end-of-plan pulse |
| total_cycles | output | TOT_W | Measured cycles spent waiting on units |
| model_cost | output | TOT_W | Analytic latency cost of the latched plan |

## Verification
The plans cover four cases:
- more large tasks than small ones, where the small work is hidden;
- more small tasks than large ones, where trailing small-only rounds add cost;
- equal counts;
- plans with one side empty or both sides empty.

Together these separate a correct overlap formula from a plain sum and from a reversed max. Unit models answer after exactly their latency. Spurious done pulses are driven on a unit that is idle while the other unit is still running; a barrier that accepts any done would show up as a shortened measured count. A second `start` pulse in the middle of a run checks that the latched plan and cost stay fixed.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_FIN
    } dcd_state_e;
endpackage

// File: rtl/dcd_unit_track.sv
module dcd_unit_track #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_num,
    input  logic             issue,
    input  logic             done_in,
    output logic             has_work,
    output logic             outstanding,
    output logic             round_clear
);
    logic [CNT_W-1:0] remaining;

    // Tasks still to hand out to this unit
    always_ff @(posedge clk) begin
        if (!rst_n)
            remaining <= '0;
        else if (load)
            remaining <= load_num;
        else if (issue)
            remaining <= remaining - 1'b1;
    end

    // A task is in flight from its issue pulse until done is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)
            outstanding <= 1'b0;
        else if (load)
            outstanding <= 1'b0;
        else if (issue)
            outstanding <= 1'b1;
        else if (done_in && outstanding)
            outstanding <= 1'b0;
    end

    always_comb begin
        has_work    = (remaining != '0);
        round_clear = !outstanding || done_in;
    end

    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !issue) |=> $stable(remaining)); // R3
    AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !issue && !outstanding) |=> !outstanding); // R7
endmodule

// File: rtl/dcd_cost_model.sv
module dcd_cost_model #(
    parameter int CNT_W = 8,
    parameter int LAT_W = 8,
    parameter int TOT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] n_big,
    input  logic [CNT_W-1:0] n_small,
    input  logic [LAT_W-1:0] l_big,
    input  logic [LAT_W-1:0] l_small,
    output logic [TOT_W-1:0] cost
);
    logic [TOT_W-1:0] big_part;
    logic [TOT_W-1:0] excess;
    logic [TOT_W-1:0] small_part;

    // Small work only costs where it outlasts the large rounds
    always_comb begin
        big_part   = TOT_W'(l_big) * TOT_W'(n_big);
        excess     = (n_small > n_big) ? TOT_W'(n_small - n_big) : '0;
        small_part = TOT_W'(l_small) * excess;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cost <= '0;
        else if (load)
            cost <= big_part + small_part;
    end

    AST_COST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cost)); // R9
endmodule

// File: rtl/dual_cu_dispatcher.sv
module dual_cu_dispatcher
    import dcd_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int LAT_W = 8,
    parameter int TOT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] num_big,
    input  logic [CNT_W-1:0] num_small,
    input  logic [LAT_W-1:0] lat_big,
    input  logic [LAT_W-1:0] lat_small,
    input  logic             done_big,
    input  logic             done_small,
    output logic             issue_big,
    output logic             issue_small,
    output logic             busy,
    output logic             finished,
    output logic [TOT_W-1:0] total_cycles,
    output logic [TOT_W-1:0] model_cost
);
    localparam int NUM_UNITS = 2;
    localparam int IDX_BIG   = 0;
    localparam int IDX_SMALL = 1;

    dcd_state_e state, state_nx;

    logic                 load;
    logic [CNT_W-1:0]     num_arr [NUM_UNITS];
    logic [NUM_UNITS-1:0] issue_vec;
    logic [NUM_UNITS-1:0] done_vec;
    logic [NUM_UNITS-1:0] work_vec;
    logic [NUM_UNITS-1:0] out_vec;
    logic [NUM_UNITS-1:0] clear_vec;

    assign num_arr[IDX_BIG]   = num_big;
    assign num_arr[IDX_SMALL] = num_small;
    assign done_vec           = {done_small, done_big};

    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            dcd_unit_track #(.CNT_W(CNT_W)) u_track (
                .clk         (clk),
                .rst_n       (rst_n),
                .load        (load),
                .load_num    (num_arr[u]),
                .issue       (issue_vec[u]),
                .done_in     (done_vec[u]),
                .has_work    (work_vec[u]),
                .outstanding (out_vec[u]),
                .round_clear (clear_vec[u])
            );
        end
    endgenerate

    dcd_cost_model #(.CNT_W(CNT_W), .LAT_W(LAT_W), .TOT_W(TOT_W)) u_cost (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .n_big   (num_big),
        .n_small (num_small),
        .l_big   (lat_big),
        .l_small (lat_small),
        .cost    (model_cost)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start)
                    state_nx = (num_big == '0 && num_small == '0) ? ST_FIN : ST_ISSUE;
            end
            ST_ISSUE: state_nx = ST_WAIT;
            ST_WAIT: begin
                if (&clear_vec)
                    state_nx = (|work_vec) ? ST_ISSUE : ST_FIN;
            end
            ST_FIN:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load        = (state == ST_IDLE) && start;
        issue_vec   = (state == ST_ISSUE) ? work_vec : '0;
        issue_big   = issue_vec[IDX_BIG];
        issue_small = issue_vec[IDX_SMALL];
        busy        = (state != ST_IDLE);
        finished    = (state == ST_FIN);
    end

    // Measured latency: cycles spent waiting on the units
    always_ff @(posedge clk) begin
        if (!rst_n)
            total_cycles <= '0;
        else if (load)
            total_cycles <= '0;
        else if (state == ST_WAIT)
            total_cycles <= total_cycles + 1'b1;
    end

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R2
    AST_NO_ISSUE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(issue_big || issue_small)); // R3
    AST_BARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_vec) |-> !(issue_big || issue_small)); // R4
    AST_TOTAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(total_cycles)); // R5
    AST_STRAY_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && out_vec[IDX_BIG] && !done_big && done_small && !out_vec[IDX_SMALL])
        |=> (state == ST_WAIT)); // R7
    AST_FINISH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        finished |=> (!finished && !busy)); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(model_cost)); // R9
endmodule

// File: tb/dual_cu_dispatcher_tb.sv
module dual_cu_dispatcher_tb;
    localparam int CNT_W = 8;
    localparam int LAT_W = 8;
    localparam int TOT_W = 20;
    localparam int NVEC  = 8;

    // {num_big, num_small, lat_big, lat_small, expected cost, expected rounds, stray enable}
    localparam int VEC [NVEC][7] = '{
        '{3, 1,  8, 2, 24, 3, 1},
        '{2, 5,  6, 3, 21, 5, 0},
        '{4, 4,  5, 2, 20, 4, 0},
        '{0, 3,  7, 2,  6, 3, 1},
        '{3, 0,  9, 4, 27, 3, 1},
        '{1, 1,  2, 1,  2, 1, 0},
        '{0, 0,  5, 2,  0, 0, 0},
        '{6, 2, 10, 5, 60, 6, 1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] num_big = '0, num_small = '0;
    logic [LAT_W-1:0] lat_big = 8'd1, lat_small = 8'd1;
    logic             done_big, done_small;
    logic             issue_big, issue_small, busy, finished;
    logic [TOT_W-1:0] total_cycles, model_cost;

    int  checks = 0;
    int  fails  = 0;
    int  emu_b = 0, emu_s = 0;
    int  cnt_ib = 0, cnt_is = 0, cnt_rounds = 0, barrier_bad = 0;
    logic stray_en = 1'b0;
    logic force_stray = 1'b0;

    always #10 clk = ~clk;

    // Unit models answer exactly lat cycles after the issue cycle
    assign done_big   = (emu_b == 1) || (stray_en && emu_b == 0) || force_stray;
    assign done_small = (emu_s == 1) || (stray_en && emu_s == 0) || force_stray;

    dual_cu_dispatcher #(.CNT_W(CNT_W), .LAT_W(LAT_W), .TOT_W(TOT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .num_big(num_big), .num_small(num_small),
        .lat_big(lat_big), .lat_small(lat_small),
        .done_big(done_big), .done_small(done_small),
        .issue_big(issue_big), .issue_small(issue_small),
        .busy(busy), .finished(finished),
        .total_cycles(total_cycles), .model_cost(model_cost)
    );

    always @(negedge clk) begin
        if (issue_big || issue_small) begin
            cnt_rounds <= cnt_rounds + 1;
            if (emu_b > 1 || emu_s > 1) barrier_bad <= barrier_bad + 1;
        end
        if (issue_big) begin
            cnt_ib <= cnt_ib + 1;
            emu_b  <= int'(lat_big) + 1;
        end else if (emu_b != 0) emu_b <= emu_b - 1;
        if (issue_small) begin
            cnt_is <= cnt_is + 1;
            emu_s  <= int'(lat_small) + 1;
        end else if (emu_s != 0) emu_s <= emu_s - 1;
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_finish(input string req);
        int guard = 0;
        while (!finished && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check({req, " watchdog"}, longint'(finished), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", busy, 0);
        check("R1 finished", finished, 0);
        check("R1 issue", issue_big | issue_small, 0);
        check("R1 total", total_cycles, 0);
        check("R1 cost", model_cost, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: stray done while idle starts nothing
        force_stray = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 idle stray busy", busy, 0);
        force_stray = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            num_big   = CNT_W'(VEC[v][0]);
            num_small = CNT_W'(VEC[v][1]);
            lat_big   = LAT_W'(VEC[v][2]);
            lat_small = LAT_W'(VEC[v][3]);
            stray_en  = VEC[v][6] != 0;
            cnt_ib = 0; cnt_is = 0; cnt_rounds = 0; barrier_bad = 0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R2 busy after start", busy, 1);
            check("R6 model cost", model_cost, VEC[v][4]);
            wait_finish("R8");
            check("R5 measured total", total_cycles, VEC[v][4]);
            check("R3 big issues", cnt_ib, VEC[v][0]);
            check("R3 small issues", cnt_is, VEC[v][1]);
            check("R3 rounds", cnt_rounds, VEC[v][5]);
            check("R4 barrier", barrier_bad, 0);
            @(negedge clk);
            check("R8 busy falls", busy, 0);
            check("R8 finished one cycle", finished, 0);
            stray_en = 1'b0;
            repeat (2) @(negedge clk);
        end

        // R9: start while busy is ignored
        num_big = 8'd2; num_small = 8'd3; lat_big = 8'd4; lat_small = 8'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        num_big = 8'd9; num_small = 8'd0; lat_big = 8'd9;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 cost kept", model_cost, 11);
        num_big = 8'd2; num_small = 8'd3; lat_big = 8'd4;
        wait_finish("R9");
        check("R9 total kept", total_cycles, 11);
        // R5: total holds after the run
        repeat (4) @(negedge clk);
        check("R5 total holds", total_cycles, 11);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule